// File: doc/BRIEF.md
# In-band command and sample demultiplexer

This block sits behind a host's 16-bit parallel write bus and splits one word stream into two destinations without any extra control pins. The top two bits of every written word act as a tag. Two tag values carry the I and Q halves of a baseband sample. The other two tag values carry a command head and its continuation words. Completed I/Q pairs leave on a valid/ready stream toward an up-conversion stage. Completed commands load the oscillator's phase increment or its phase offset.

Commands and samples may be interleaved word by word. The sample path and the command path keep separate sequencing state, so a command that is being assembled never delays or drops a sample. The frequency word is built in a shadow register and becomes live in a single cycle. A one-cycle pulse marks each register update so that downstream phase logic can resynchronise. A sticky flag records any tag sequence that breaks the rules.

The input bus cannot stall. The output stream therefore holds one pair. Each pair stays stable while `smp_valid` is high and `smp_ready` is low. A pair that completes while the previous one has not been taken is dropped and raises the error flag. A sink that takes a pair within two bus writes never loses data.

Top module: `inband_demux`

## Requirements
- R1: While `rst_n` is low, and after reset, `smp_valid`, `cfg_commit` and `seq_err` are 0, and `nco_freq` and `nco_phase` are 0.
- R2: Only bits 15:14 of a written word select its kind: 00 is an I sample, 01 is a Q sample, 10 is a command head and 11 is a continuation word. Bits 13:0 are the payload.
- R3: An I word followed by a Q word sets `smp_valid` in the cycle after the Q write. `smp_i` and `smp_q` then show the two 14-bit two's-complement payloads.
- R4: While `smp_valid` is 1 and `smp_ready` is 0, `smp_valid`, `smp_i` and `smp_q` hold steady. A cycle with both high empties the output.
- R5: If a Q word completes a pair while an earlier pair is still held and `smp_ready` is low, the new pair is discarded, the held pair is kept, and `seq_err` is set.
- R6: A head with address 0 (bits 13:8) opens a frequency command that takes two continuation words. `nco_freq` becomes the low 32 bits of {head bits 7:0, first payload, second payload}. It changes only in the cycle after the last continuation word is written.
- R7: A head with address 1 opens a phase command that takes one continuation word. `nco_phase` becomes the low 16 bits of {head bits 7:0, continuation payload}.
- R8: `cfg_commit` is high for exactly the one cycle in which `nco_freq` or `nco_phase` takes a new value.
- R9: Sample words written between the words of an open command are paired and emitted normally, and the command still commits.
- R10: `seq_err` is set when any of these occur: an I word while an I word is pending (the old I is replaced), a Q word with no pending I (it is dropped), a continuation word with no open command (it is ignored), a head while a command is open (the partial command is discarded and the new head opens), or a head with an unknown address (no command opens).
- R11: Words presented while `bus_we` is low have no effect on any output.
- R12: `seq_err` stays set until reset, through later correct traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_word | input | 16 | Host bus data word |
| bus_we | input | 1 | Write strobe qualifying `bus_word` |
| smp_valid | output | 1 | A sample pair is available |
| smp_ready | input | 1 | Sink accepts the pair |
| smp_i | output | 14 | In-phase sample |
| smp_q | output | 14 | Quadrature sample |
| nco_freq | output | 32 | Live oscillator phase increment |
| nco_phase | output | 16 | Live oscillator phase offset |
| cfg_commit | output | 1 | One-cycle pulse on a register update |
| seq_err | output | 1 | Sticky sequence error flag |

## Verification
The bench checks the frequency word after each of its three command words. A design that wrote through without a shadow would expose a half-updated increment before the last word. It interleaves samples inside an open command: a single shared sequencer would drop the pair or abort the command. It stalls the sink while a second pair completes, where a careless output stage would overwrite the held pair. It then walks through each out-of-order tag case and checks which partial state survives. A design that kept the stale I word, or let an abandoned frequency head commit, would show the wrong pair or register value.

// File: rtl/ibdmx_pkg.sv
package ibdmx_pkg;
  localparam int WORD_W = 16;
  localparam int TAG_W  = 2;
  localparam int PAY_W  = WORD_W - TAG_W;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = PAY_W - BYTE_W;

  typedef enum logic [TAG_W-1:0] {
    TAG_I    = 2'b00,
    TAG_Q    = 2'b01,
    TAG_HEAD = 2'b10,
    TAG_CONT = 2'b11
  } tag_e;
endpackage

// File: rtl/ibdmx_pair_seq.sv
module ibdmx_pair_seq
  import ibdmx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WORD_W-1:0] word,
  output logic              o_valid,
  input  logic              o_ready,
  output logic [PAY_W-1:0]  o_i,
  output logic [PAY_W-1:0]  o_q,
  output logic              err
);
  tag_e             tag;
  logic [PAY_W-1:0] payload;
  logic             pend;
  logic [PAY_W-1:0] i_hold;
  logic             is_i, is_q, slot_free;

  assign tag       = tag_e'(word[WORD_W-1 -: TAG_W]);
  assign payload   = word[PAY_W-1:0];
  assign is_i      = we && (tag == TAG_I);
  assign is_q      = we && (tag == TAG_Q);
  assign slot_free = !o_valid || o_ready;

  always_comb begin
    err = (is_i && pend) || (is_q && !pend) || (is_q && pend && !slot_free);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      i_hold  <= '0;
      o_valid <= 1'b0;
      o_i     <= '0;
      o_q     <= '0;
    end else begin
      if (o_valid && o_ready) o_valid <= 1'b0;
      if (is_i) begin
        pend   <= 1'b1;
        i_hold <= payload;
      end else if (is_q) begin
        pend <= 1'b0;
        if (pend && slot_free) begin
          o_valid <= 1'b1;
          o_i     <= i_hold;
          o_q     <= payload;
        end
      end
    end
  end
endmodule

// File: rtl/ibdmx_cmd_asm.sv
module ibdmx_cmd_asm
  import ibdmx_pkg::*;
#(
  parameter int FREQ_W     = 32,
  parameter int PHASE_W    = 16,
  parameter int ADDR_FREQ  = 0,
  parameter int ADDR_PHASE = 1,
  localparam int ACC_W     = (FREQ_W > PHASE_W) ? FREQ_W : PHASE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WORD_W-1:0] word,
  output logic              wr_en,
  output logic              wr_is_freq,
  output logic [ACC_W-1:0]  wr_data,
  output logic              err
);
  localparam int FREQ_CONT  = (FREQ_W  - BYTE_W + PAY_W - 1) / PAY_W;
  localparam int PHASE_CONT = (PHASE_W - BYTE_W + PAY_W - 1) / PAY_W;
  localparam int MAX_CONT   = (FREQ_CONT > PHASE_CONT) ? FREQ_CONT : PHASE_CONT;
  localparam int CNT_W      = $clog2(MAX_CONT + 1);

  tag_e              tag;
  logic [ADDR_W-1:0] addr;
  logic              is_head, is_cont, addr_freq, addr_known;
  logic              open_r, freq_r;
  logic [CNT_W-1:0]  left;
  logic [ACC_W-1:0]  acc, next_acc;

  assign tag        = tag_e'(word[WORD_W-1 -: TAG_W]);
  assign addr       = word[PAY_W-1 -: ADDR_W];
  assign is_head    = we && (tag == TAG_HEAD);
  assign is_cont    = we && (tag == TAG_CONT);
  assign addr_freq  = (addr == ADDR_W'(ADDR_FREQ));
  assign addr_known = addr_freq || (addr == ADDR_W'(ADDR_PHASE));
  assign next_acc   = ACC_W'({acc, word[PAY_W-1:0]});

  assign wr_en      = is_cont && open_r && (left == CNT_W'(1));
  assign wr_is_freq = freq_r;
  assign wr_data    = next_acc;
  assign err        = (is_head && (open_r || !addr_known)) || (is_cont && !open_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_r <= 1'b0;
      freq_r <= 1'b0;
      left   <= '0;
      acc    <= '0;
    end else if (is_head) begin
      open_r <= addr_known;
      freq_r <= addr_freq;
      left   <= addr_freq ? CNT_W'(FREQ_CONT) : CNT_W'(PHASE_CONT);
      acc    <= ACC_W'(word[BYTE_W-1:0]);
    end else if (is_cont && open_r) begin
      acc  <= next_acc;
      left <= left - CNT_W'(1);
      if (left == CNT_W'(1)) open_r <= 1'b0;
    end
  end
endmodule

// File: rtl/ibdmx_cfg_bank.sv
module ibdmx_cfg_bank #(
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 16,
  parameter int ACC_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_is_freq,
  input  logic [ACC_W-1:0]   wr_data,
  output logic [FREQ_W-1:0]  freq,
  output logic [PHASE_W-1:0] phase,
  output logic               commit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq   <= '0;
      phase  <= '0;
      commit <= 1'b0;
    end else begin
      commit <= wr_en;
      if (wr_en) begin
        if (wr_is_freq) freq <= wr_data[FREQ_W-1:0];
        else            phase <= wr_data[PHASE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/inband_demux.sv
module inband_demux
  import ibdmx_pkg::*;
#(
  parameter int FREQ_W     = 32,
  parameter int PHASE_W    = 16,
  parameter int ADDR_FREQ  = 0,
  parameter int ADDR_PHASE = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WORD_W-1:0]  bus_word,
  input  logic               bus_we,
  output logic               smp_valid,
  input  logic               smp_ready,
  output logic [PAY_W-1:0]   smp_i,
  output logic [PAY_W-1:0]   smp_q,
  output logic [FREQ_W-1:0]  nco_freq,
  output logic [PHASE_W-1:0] nco_phase,
  output logic               cfg_commit,
  output logic               seq_err
);
  localparam int ACC_W = (FREQ_W > PHASE_W) ? FREQ_W : PHASE_W;

  logic             pair_err, cmd_err, wr_en, wr_is_freq;
  logic [ACC_W-1:0] wr_data;

  ibdmx_pair_seq u_pair (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .word(bus_word),
    .o_valid(smp_valid), .o_ready(smp_ready), .o_i(smp_i), .o_q(smp_q),
    .err(pair_err)
  );

  ibdmx_cmd_asm #(
    .FREQ_W(FREQ_W), .PHASE_W(PHASE_W),
    .ADDR_FREQ(ADDR_FREQ), .ADDR_PHASE(ADDR_PHASE)
  ) u_cmd (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .word(bus_word),
    .wr_en(wr_en), .wr_is_freq(wr_is_freq), .wr_data(wr_data), .err(cmd_err)
  );

  ibdmx_cfg_bank #(.FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .ACC_W(ACC_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_is_freq(wr_is_freq),
    .wr_data(wr_data), .freq(nco_freq), .phase(nco_phase), .commit(cfg_commit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   seq_err <= 1'b0;
    else if (pair_err || cmd_err) seq_err <= 1'b1;
  end
endmodule

// File: rtl/inband_demux_chk.sv
module inband_demux_chk #(
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 16,
  parameter int PAY_W   = 14
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_we,
  input logic               smp_valid,
  input logic               smp_ready,
  input logic [PAY_W-1:0]   smp_i,
  input logic [PAY_W-1:0]   smp_q,
  input logic [FREQ_W-1:0]  nco_freq,
  input logic [PHASE_W-1:0] nco_phase,
  input logic               cfg_commit,
  input logic               seq_err
);
  // R4: a stalled pair does not move
  a_r4_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_i) && $stable(smp_q)));

  // R6: the increment moves only alongside the update pulse
  a_r6_freq_atomic: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_commit |-> $stable(nco_freq));

  // R7: the offset moves only alongside the update pulse
  a_r7_phase_atomic: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_commit |-> $stable(nco_phase));

  // R8: the update pulse lasts one cycle
  a_r8_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_commit |=> !cfg_commit);

  // R11: no write, no new pair and no update
  a_r11_idle_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> (!cfg_commit && !$rose(smp_valid)));

  // R12: the error flag never clears outside reset
  a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);
endmodule

bind inband_demux inband_demux_chk #(
  .FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .PAY_W(ibdmx_pkg::PAY_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .smp_valid(smp_valid),
  .smp_ready(smp_ready), .smp_i(smp_i), .smp_q(smp_q), .nco_freq(nco_freq),
  .nco_phase(nco_phase), .cfg_commit(cfg_commit), .seq_err(seq_err)
);

// File: tb/tb_inband_demux.sv
`timescale 1ns/1ps
module tb_inband_demux;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_word = '0;
  logic        bus_we = 1'b0;
  logic        smp_ready = 1'b0;
  logic        smp_valid, cfg_commit, seq_err;
  logic [13:0] smp_i, smp_q;
  logic [31:0] nco_freq;
  logic [15:0] nco_phase;
  int errors = 0;
  int total = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  inband_demux dut (
    .clk(clk), .rst_n(rst_n), .bus_word(bus_word), .bus_we(bus_we),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_i(smp_i), .smp_q(smp_q),
    .nco_freq(nco_freq), .nco_phase(nco_phase), .cfg_commit(cfg_commit),
    .seq_err(seq_err)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    bus_we = 1'b0;
    smp_ready = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic put(input logic [15:0] w);
    bus_word = w;
    bus_we = 1'b1;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  function automatic logic [15:0] w_i(input logic [13:0] v); return {2'b00, v}; endfunction
  function automatic logic [15:0] w_q(input logic [13:0] v); return {2'b01, v}; endfunction
  function automatic logic [15:0] w_h(input logic [5:0] a, input logic [7:0] b); return {2'b10, a, b}; endfunction
  function automatic logic [15:0] w_c(input logic [13:0] v); return {2'b11, v}; endfunction

  task automatic send_freq(input logic [31:0] v);
    put(w_h(6'd0, {4'h0, v[31:28]}));
    put(w_c(v[27:14]));
    put(w_c(v[13:0]));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle(1);
    chk("R1", "valid in reset", {31'd0, smp_valid}, 32'd0);
    do_reset();
    chk("R1", "valid", {31'd0, smp_valid}, 32'd0);
    chk("R1", "freq", nco_freq, 32'd0);
    chk("R1", "phase", {16'd0, nco_phase}, 32'd0);
    chk("R1", "commit/err", {30'd0, cfg_commit, seq_err}, 32'd0);
  endtask

  task automatic t_pair();
    do_reset();
    put(w_i(14'h1A5C));
    chk("R3", "valid after I only", {31'd0, smp_valid}, 32'd0);
    put(w_q(14'h3FFF));
    chk("R3", "valid after Q", {31'd0, smp_valid}, 32'd1);
    chk("R2", "I payload", {18'd0, smp_i}, 32'h1A5C);
    chk("R2", "Q payload", {18'd0, smp_q}, 32'h3FFF);
    idle(3);
    chk("R4", "held valid", {31'd0, smp_valid}, 32'd1);
    chk("R4", "held pair", {4'd0, smp_i, smp_q}, {4'd0, 14'h1A5C, 14'h3FFF});
    smp_ready = 1'b1;
    idle(1);
    chk("R4", "emptied", {31'd0, smp_valid}, 32'd0);
    put(w_i(14'h2000));
    put(w_q(14'h0001));
    chk("R3", "second pair", {3'd0, smp_valid, smp_i, smp_q}, {3'd0, 1'b1, 14'h2000, 14'h0001});
    chk("R3", "no error", {31'd0, seq_err}, 32'd0);
  endtask

  task automatic t_freq();
    logic [31:0] v = 32'hA5C3_1E97;
    do_reset();
    put(w_h(6'd0, {4'h0, v[31:28]}));
    chk("R6", "after head", nco_freq, 32'd0);
    put(w_c(v[27:14]));
    chk("R6", "after first cont", nco_freq, 32'd0);
    chk("R8", "no pulse yet", {31'd0, cfg_commit}, 32'd0);
    put(w_c(v[13:0]));
    chk("R6", "after last cont", nco_freq, v);
    chk("R8", "pulse", {31'd0, cfg_commit}, 32'd1);
    idle(1);
    chk("R8", "pulse ends", {31'd0, cfg_commit}, 32'd0);
    chk("R6", "freq kept", nco_freq, v);
  endtask

  task automatic t_phase();
    logic [15:0] v = 16'hBEEF;
    put(w_h(6'd1, {6'd0, v[15:14]}));
    chk("R7", "after head", {16'd0, nco_phase}, 32'd0);
    put(w_c(v[13:0]));
    chk("R7", "phase", {16'd0, nco_phase}, {16'd0, v});
    chk("R8", "phase pulse", {31'd0, cfg_commit}, 32'd1);
    chk("R7", "freq untouched", nco_freq, 32'hA5C3_1E97);
    chk("R7", "no error", {31'd0, seq_err}, 32'd0);
  endtask

  task automatic t_interleave();
    logic [31:0] v = 32'h1234_5678;
    do_reset();
    smp_ready = 1'b1;
    put(w_h(6'd0, {4'h0, v[31:28]}));
    put(w_i(14'h0ABC));
    put(w_c(v[27:14]));
    put(w_q(14'h3123));
    chk("R9", "pair inside command", {3'd0, smp_valid, smp_i, smp_q}, {3'd0, 1'b1, 14'h0ABC, 14'h3123});
    chk("R9", "freq not yet", nco_freq, 32'd0);
    put(w_c(v[13:0]));
    chk("R9", "command commits", nco_freq, v);
    chk("R9", "no error", {31'd0, seq_err}, 32'd0);
  endtask

  task automatic t_backpressure();
    do_reset();
    put(w_i(14'h0111));
    put(w_q(14'h0222));
    put(w_i(14'h0333));
    put(w_q(14'h0444));
    chk("R5", "held pair kept", {4'd0, smp_i, smp_q}, {4'd0, 14'h0111, 14'h0222});
    chk("R5", "error set", {31'd0, seq_err}, 32'd1);
    smp_ready = 1'b1;
    idle(1);
    chk("R5", "dropped pair not shown", {31'd0, smp_valid}, 32'd0);
  endtask

  task automatic t_seq_errors();
    do_reset();
    smp_ready = 1'b1;
    put(w_i(14'h0AAA));
    put(w_i(14'h0BBB));
    put(w_q(14'h0CCC));
    chk("R10", "I I Q pair", {3'd0, smp_valid, smp_i, smp_q}, {3'd0, 1'b1, 14'h0BBB, 14'h0CCC});
    chk("R10", "I I error", {31'd0, seq_err}, 32'd1);
    do_reset();
    put(w_q(14'h0DDD));
    chk("R10", "lone Q dropped", {31'd0, smp_valid}, 32'd0);
    chk("R10", "lone Q error", {31'd0, seq_err}, 32'd1);
    do_reset();
    put(w_c(14'h1555));
    chk("R10", "lone cont ignored", {nco_freq[30:0], cfg_commit}, 32'd0);
    chk("R10", "lone cont error", {31'd0, seq_err}, 32'd1);
    do_reset();
    put(w_h(6'd0, 8'h0F));
    put(w_h(6'd1, 8'h02));
    put(w_c(14'h0042));
    chk("R10", "restarted phase", {16'd0, nco_phase}, 32'h0000_8042);
    chk("R10", "abandoned freq", nco_freq, 32'd0);
    chk("R10", "head over open", {31'd0, seq_err}, 32'd1);
    do_reset();
    put(w_h(6'd5, 8'h11));
    put(w_c(14'h0101));
    chk("R10", "unknown address no commit", {31'd0, cfg_commit}, 32'd0);
    chk("R10", "unknown address regs", {nco_freq[15:0], nco_phase}, 32'd0);
    chk("R10", "unknown address error", {31'd0, seq_err}, 32'd1);
  endtask

  task automatic t_ignore();
    do_reset();
    smp_ready = 1'b1;
    bus_we = 1'b0;
    bus_word = w_i(14'h0123); idle(1);
    bus_word = w_q(14'h0456); idle(1);
    bus_word = w_h(6'd1, 8'h03); idle(1);
    bus_word = w_c(14'h3FFF); idle(1);
    bus_word = w_c(14'h3FFF); idle(1);
    chk("R11", "no pair", {31'd0, smp_valid}, 32'd0);
    chk("R11", "no update", {nco_phase, 15'd0, cfg_commit}, 32'd0);
    chk("R11", "no error", {31'd0, seq_err}, 32'd0);
  endtask

  task automatic t_sticky();
    do_reset();
    put(w_q(14'h0001));
    smp_ready = 1'b1;
    put(w_i(14'h0002));
    put(w_q(14'h0003));
    send_freq(32'h0000_0100);
    idle(2);
    chk("R12", "still set", {31'd0, seq_err}, 32'd1);
    chk("R12", "traffic works", nco_freq, 32'h0000_0100);
    do_reset();
    chk("R1", "cleared by reset", {31'd0, seq_err}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, total);
      $finish;
    end
  end

  initial begin
    #2;
    t_reset();
    t_pair();
    t_freq();
    t_phase();
    t_interleave();
    t_backpressure();
    t_seq_errors();
    t_ignore();
    t_sticky();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end
endmodule